// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a periodic tick source built around a down-counter. Software programs a reload value and turns the counter on. The counter then steps down once per selected tick. On the step from one to zero it raises a sticky wrap flag and, if allowed, sends out a one-cycle interrupt pulse. On the tick after that it reloads, so the wrap events repeat with a period of the reload value plus one ticks.

Ticks come from one of two sources. The first is every cycle of the core clock. The second is the rising edges of a slower external reference, which is first brought into the core clock domain.

Three registers sit on a simple single-cycle register port: control/status, reload and current count. The port has no back-pressure. Every strobe is accepted in the cycle it is presented. Read data comes back on the next cycle, marked by a valid pulse. The caller must take that data in that cycle, because there is no ready input to hold it.

Top module: `tick_down_timer`

## Requirements
- R1: The reload register keeps only the low 24 bits of a written word. A read of the reload register returns those bits with bits 31..24 as zero.
- R2: Each enabled tick lowers a nonzero count by one. The step from 1 to 0 sets the sticky wrap flag, which reads at bit 16 of the control register. The next tick after a zero count loads the reload value, so wraps recur every reload+1 ticks.
- R3: `irq_o` is a one-cycle pulse. It is asserted in the cycle after the 1-to-0 step, and only when the interrupt-enable bit (control bit 1) is set. The wrap flag is set whether or not that bit is set.
- R4: A write of any data to the current-count register (address 2) clears the count to 0 and clears the wrap flag.
- R5: With a reload value of 0 the count stays at 0. No flag is set and no interrupt is raised.
- R6: The control register holds three bits: run enable at bit 0, interrupt enable at bit 1 and source select at bit 2. Writing 0 to it freezes the count and stops interrupts.
- R7: Source select 1 ticks on every core clock cycle. Source select 0 ticks once per rising edge of `ref_clk_i`, after a two-flop synchroniser. With no reference edges, the counter does not tick.
- R8: A read of the control register returns the wrap flag together with the three control bits, then clears the flag. If a wrap happens in the same cycle as the read, the wrap is kept and the flag stays set.
- R9: When the counter is started while it holds 0, the first tick loads the reload value without setting the flag. The first interrupt then comes reload+1 ticks after the start.
- R10: The register addresses are 0 for control, 1 for reload, 2 for current count and 3 for an unused slot that reads as zero. Read data appears on `bus_rdata_o` in the cycle after the strobe, with `bus_rvalid_o` high for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Slow external reference, asynchronous to `clk` |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid_o | output | 1 | Marks the cycle in which `bus_rdata_o` is valid |
| irq_o | output | 1 | One-cycle interrupt pulse on a wrap |

## Verification
The interrupt pulse is registered. It appears one cycle after the tick edge that takes the count from 1 to 0. When the counter is started from zero on the core clock, this is reload+1 cycles after the edge that latches the control write. The bench counts falling edges from the end of that write and expects exactly that number. Read data is registered at the edge that samples the strobe, so the bench drives the strobe at one falling edge and samples the data at the next. Reference-clock results carry a further three-flop delay, so for those the bench compares only the spacing between successive pulses, which is independent of that constant delay.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_RELOAD  = 2'd1,
    ADDR_CURRENT = 2'd2,
    ADDR_SPARE   = 2'd3
  } tdt_addr_e;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } tdt_ctrl_t;
endpackage

// File: rtl/tdt_ref_sync.sv
module tdt_ref_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);
  localparam int LAST = SYNC_N;

  // chain[0..SYNC_N-1] are the synchroniser stages, chain[LAST] holds the previous value
  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)               cnt_d = CNT_ZERO;
    else if (tick_i) begin
      if (cnt_q == CNT_ZERO)   cnt_d = reload_i;
      else                     cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_d;
  end

  // only the 1 -> 0 step counts as a wrap; a software clear suppresses it
  assign wrap_o = tick_i & ~clear_i & (cnt_q == CNT_ONE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output tdt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              cur_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  tdt_addr_e        addr;
  logic             wr_hit;
  logic             rd_hit;
  logic             ctrl_wr;
  logic             reload_wr;
  logic             ctrl_rd;
  tdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata_hi;

  assign addr      = tdt_addr_e'(addr_i);
  assign wr_hit    = sel_i & wr_i;
  assign rd_hit    = sel_i & ~wr_i;
  assign ctrl_wr   = wr_hit && (addr == ADDR_CTRL);
  assign reload_wr = wr_hit && (addr == ADDR_RELOAD);
  assign cur_wr_o  = wr_hit && (addr == ADDR_CURRENT);
  assign ctrl_rd   = rd_hit && (addr == ADDR_CTRL);
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.en  <= wdata_i[BIT_EN];
      ctrl_q.ie  <= wdata_i[BIT_IE];
      ctrl_q.src <= wdata_i[BIT_SRC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= wdata_i[CNT_W-1:0];
  end

  // clear by count write beats a wrap; a wrap beats the clear-on-read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (cur_wr_o) flag_q <= 1'b0;
    else if (wrap_i)   flag_q <= 1'b1;
    else if (ctrl_rd)  flag_q <= 1'b0;
  end

  always_comb begin
    rd_word = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rd_word[BIT_EN]   = ctrl_q.en;
        rd_word[BIT_IE]   = ctrl_q.ie;
        rd_word[BIT_SRC]  = ctrl_q.src;
        rd_word[BIT_FLAG] = flag_q;
      end
      ADDR_RELOAD:  rd_word[CNT_W-1:0] = reload_q;
      ADDR_CURRENT: rd_word[CNT_W-1:0] = cnt_i;
      ADDR_SPARE:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_hit;
      if (rd_hit) rdata_o <= rd_word;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  tdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_w;
  logic             flag_w;
  logic             cur_wr_w;
  logic             ref_rise;
  logic             tick_w;
  logic             wrap_w;
  logic             irq_q;

  tdt_ref_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_clk_i),
    .rise_o (ref_rise)
  );

  assign tick_w = ctrl.en & (ctrl.src | ref_rise);

  tdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_w),
    .clear_i  (cur_wr_w),
    .reload_i (reload_w),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  tdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cnt_i    (cnt_w),
    .wrap_i   (wrap_w),
    .ctrl_o   (ctrl),
    .reload_o (reload_w),
    .flag_o   (flag_w),
    .cur_wr_o (cur_wr_w),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap_w & ctrl.ie;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tdt_checks.sv
module tdt_checks #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cur_wr,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             flag,
  input logic             irq
);
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_wr && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_reload_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_wr && cnt == '0) |=> cnt == $past(reload));

  assert_irq_has_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_irq_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cnt == '0 && !flag));

  assert_zero_reload_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && cnt == '0) |=> !irq);

  assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cur_wr) |=> $stable(cnt));
endmodule

bind tick_down_timer tdt_checks #(.CNT_W(CNT_W)) u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick_w),
  .cur_wr (cur_wr_w),
  .en     (ctrl.en),
  .cnt    (cnt_w),
  .reload (reload_w),
  .flag   (flag_w),
  .irq    (irq_o)
);

// File: tb/tick_down_timer_bench.sv
module tick_down_timer_bench;
  localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_CUR = 2'd2, A_SPARE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;
  logic        ref_run = 1'b0;
  int          ref_cnt = 0;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tick_down_timer u_tick_down_timer (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  // reference: toggles every 4 core cycles, so one rising edge per 8 cycles
  always @(negedge clk) begin
    if (ref_run) begin
      ref_cnt = ref_cnt + 1;
      if (ref_cnt == 4) begin
        ref_cnt = 0;
        ref_clk = ~ref_clk;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
    v = rvalid;
  endtask

  task automatic wait_irq(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < limit);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, a0;
    logic        v;
    int          n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL, d, v);   chk("R6 reset ctrl", d, 32'h0);
    chk("R10 rvalid on read", {31'b0, v}, 32'h1);
    bus_read(A_RELOAD, d, v); chk("R1 reset reload", d, 32'h0);
    bus_read(A_CUR, d, v);    chk("R4 reset count", d, 32'h0);

    // R1 upper bits dropped
    bus_write(A_RELOAD, 32'hABCD_EF12);
    bus_read(A_RELOAD, d, v); chk("R1 reload width", d, 32'h00CD_EF12);
    bus_read(A_SPARE, d, v);  chk("R10 spare slot", d, 32'h0);

    // R2/R9 sweep over small reload values on the core clock
    for (int r = 1; r <= 8; r++) begin
      bus_write(A_CTRL, 32'h0);
      bus_write(A_CUR, 32'h0);
      bus_write(A_RELOAD, r);
      bus_write(A_CTRL, 32'h7);
      wait_irq(100, n); chk($sformatf("R9 first wrap reload=%0d", r), n, r + 1);
      wait_irq(100, n); chk($sformatf("R2 period reload=%0d", r), n, r + 1);
      wait_irq(100, n); chk($sformatf("R2 period again reload=%0d", r), n, r + 1);
    end

    // R8 flag readable and cleared on read
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, d, v); chk("R8 flag set on read", d, 32'h0001_0000);
    bus_read(A_CTRL, d, v); chk("R8 flag cleared by read", d, 32'h0);
    bus_write(A_CTRL, 32'hFFFF_FFF6);
    bus_read(A_CTRL, d, v); chk("R6 control fields", d, 32'h6);

    // R3 no interrupt without enable, flag still set
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CUR, 32'h0);
    bus_write(A_RELOAD, 32'd5);
    bus_write(A_CTRL, 32'h5);
    wait_irq(60, n); chk("R3 no irq when disabled", n, 60);
    bus_read(A_CTRL, d, v); chk("R3 flag without irq", d, 32'h0001_0005);

    // R5 zero reload
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CUR, 32'h0);
    bus_write(A_RELOAD, 32'h0);
    bus_write(A_CTRL, 32'h7);
    wait_irq(50, n); chk("R5 zero reload no irq", n, 50);
    bus_read(A_CTRL, d, v); chk("R5 zero reload no flag", d, 32'h7);
    bus_read(A_CUR, d, v);  chk("R5 count stays zero", d, 32'h0);

    // R4 write to count clears count and flag
    bus_write(A_CTRL, 32'h0);
    bus_write(A_RELOAD, 32'd20);
    bus_write(A_CTRL, 32'h5);
    repeat (50) @(negedge clk);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CUR, 32'h0000_0123);
    bus_read(A_CUR, d, v);  chk("R4 count cleared", d, 32'h0);
    bus_read(A_CTRL, d, v); chk("R4 flag cleared", d, 32'h0);

    // R6 stop freezes the count
    bus_write(A_RELOAD, 32'd10);
    bus_write(A_CTRL, 32'h7);
    repeat (17) @(negedge clk);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CUR, d, v); a0 = d;
    repeat (20) @(negedge clk);
    bus_read(A_CUR, d, v); chk("R6 count frozen", d, a0);
    wait_irq(30, n); chk("R6 no irq while stopped", n, 30);

    // R7 external reference: one tick per rising edge (8 core cycles)
    bus_write(A_CUR, 32'h0);
    bus_write(A_RELOAD, 32'd2);
    ref_run = 1'b1;
    bus_write(A_CTRL, 32'h3);
    wait_irq(400, n);
    wait_irq(400, n); chk("R7 reference period", n, 24);
    wait_irq(400, n); chk("R7 reference period again", n, 24);
    ref_run = 1'b0;
    wait_irq(200, n); chk("R7 no reference edges no ticks", n, 200);

    finish_run();
  end
endmodule